// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, in one combinational pass, whether a memory access may proceed under a set of physical memory protection entries. Each entry has an 8-bit configuration byte and an address register. The configuration byte holds a match mode, read/write/execute grant bits and a lock bit. The address register holds a word address, which is bits [XLEN+1:2] of a byte address. The block decodes every entry into a byte range at the moment of the check. It scans the entries from index 0 upward and returns one allow bit.

The caller supplies the access byte address (XLEN+2 bits), the access size in bytes, the requested permission set, whether the hart is in machine mode, and the flattened contents of all entry registers. The caller must register the result or use it as a fault condition. Register storage, write locking and fault encoding belong to the surrounding logic.

Top module: `pmp_access_checker`

## Requirements
- R1: Region bounds are formed from an address register shifted left by two. In 4-byte mode (mode bits 4:3 = 2) the region covers exactly the shifted address through the shifted address plus three.
- R2: In top-of-range mode (mode bits = 1), the region starts at the previous entry's address register shifted left by two, whatever that entry's mode is. It ends one byte below this entry's shifted address. Entry 0 uses zero as its previous address. The region is empty when the upper bound is not above the lower bound.
- R3: In power-of-two mode (mode bits = 3), with t trailing ones in the address register, the base is the register with its low t bits cleared, shifted left by two. The size is 2^(t+3) bytes. An address register of all ones covers the whole address space.
- R4: An entry whose mode bits are 0 (off) never matches and never affects the result, whatever its address register holds.
- R5: Among entries that contain the first byte or the last byte of the access, the lowest-indexed one alone decides the outcome.
- R6: If the deciding entry contains exactly one of the first byte and the last byte, the access is denied in every mode.
- R7: If the deciding entry contains the whole access, is not locked (bit 7 clear), and the hart is in machine mode, the access is allowed.
- R8: Otherwise, for a fully contained access, the grant set is the entry's bits 2:0 (bit 0 read, bit 1 write, bit 2 execute). The access is allowed only if every requested permission bit (same bit order) is in the grant set.
- R9: If every entry is off, every access is allowed.
- R10: If at least one entry is active and none contains either end of the access, the access is allowed in machine mode and denied otherwise.
- R11: A size of zero is treated as one byte. An access whose last byte lies past the top of the address space has that last byte outside every region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | XLEN+2 | Byte address of the first byte of the access |
| acc_size | input | SIZE_W | Access length in bytes (0 treated as 1) |
| acc_perm | input | 3 | Requested permissions: bit0 read, bit1 write, bit2 execute |
| machine_mode | input | 1 | High when the access is made from machine mode |
| entry_cfg | input | NUM_ENTRIES*8 | Configuration bytes, entry i at bits [8i+7:8i] |
| entry_addr | input | NUM_ENTRIES*XLEN | Address registers, entry i at bits [XLEN*i+XLEN-1:XLEN*i] |
| acc_allow | output | 1 | High when the access is permitted |

## Verification
The checker watches several rules on every evaluation of the inputs: off entries never producing a hit, the deciding entry being the lowest hit, straddling accesses always being refused, unlocked machine-mode containment being granted, and the no-entry and no-match fallbacks. Only the bench scenarios can show that the decoded ranges sit at the right byte addresses. These scenarios cover the last byte of a 4-byte region, empty and zero-based top-of-range regions, the whole-space power-of-two case, wrap past the top of the address space, and lock-bit handling in machine mode.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  // Match mode encoding held in configuration bits 4:3.
  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_mode_e;

  localparam int CFG_W    = 8;
  localparam int PERM_W   = 3;
  localparam int MODE_LSB = 3;
  localparam int LOCK_BIT = 7;

  function automatic match_mode_e cfg_mode(input logic [CFG_W-1:0] cfg);
    return match_mode_e'(cfg[MODE_LSB +: 2]);
  endfunction

endpackage

// File: rtl/pmp_region_decode.sv
module pmp_region_decode
  import pmp_chk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  match_mode_e     mode,
  input  logic [XLEN-1:0] cur_addr,
  input  logic [XLEN-1:0] prev_addr,
  output logic [XLEN+2:0] lo_bound,
  output logic [XLEN+2:0] hi_bound,
  output logic            active
);
  localparam int BND_W = XLEN + 3;
  localparam logic [XLEN-1:0]  WORD_ONE = XLEN'(1);
  localparam logic [BND_W-1:0] BND_ONE  = BND_W'(1);
  localparam logic [BND_W-1:0] NA4_SIZE = BND_W'(4);
  localparam logic [BND_W-1:0] FULL_HI  = BND_ONE << (XLEN + 2);

  logic [XLEN-1:0]  ones_mask;
  logic [XLEN-1:0]  low_mask;
  logic [BND_W-1:0] cur_b;
  logic [BND_W-1:0] prev_b;
  logic [BND_W-1:0] napot_base;
  logic [BND_W-1:0] napot_size;
  logic             all_ones;

  always_comb begin
    cur_b      = {1'b0, cur_addr, 2'b00};
    prev_b     = {1'b0, prev_addr, 2'b00};
    // Bits 0..t set where t is the count of trailing ones.
    ones_mask  = cur_addr ^ (cur_addr + WORD_ONE);
    low_mask   = ones_mask >> 1;
    all_ones   = &cur_addr;
    napot_base = {1'b0, cur_addr & ~low_mask, 2'b00};
    napot_size = ({3'b000, low_mask} + BND_ONE) << 3;

    lo_bound = '0;
    hi_bound = '0;
    active   = 1'b1;
    case (mode)
      MATCH_TOR: begin
        lo_bound = prev_b;
        hi_bound = cur_b;
      end
      MATCH_NA4: begin
        lo_bound = cur_b;
        hi_bound = cur_b + NA4_SIZE;
      end
      MATCH_NAPOT: begin
        if (all_ones) begin
          lo_bound = '0;
          hi_bound = FULL_HI;
        end else begin
          lo_bound = napot_base;
          hi_bound = napot_base + napot_size;
        end
      end
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match #(
  parameter int BND_W = 35
) (
  input  logic             active,
  input  logic [BND_W-1:0] lo_bound,
  input  logic [BND_W-1:0] hi_bound,
  input  logic [BND_W-1:0] first_byte,
  input  logic [BND_W-1:0] last_byte,
  output logic             full_hit,
  output logic             part_hit
);
  logic in_first;
  logic in_last;

  always_comb begin
    in_first = active && (first_byte >= lo_bound) && (first_byte < hi_bound);
    in_last  = active && (last_byte  >= lo_bound) && (last_byte  < hi_bound);
    full_hit = in_first && in_last;
    part_hit = in_first ^ in_last;
  end
endmodule

// File: rtl/pmp_priority_select.sv
module pmp_priority_select #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] full_vec,
  input  logic [NUM_ENTRIES-1:0] part_vec,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output logic                   win_part
);
  logic [NUM_ENTRIES-1:0] any_vec;

  always_comb begin
    any_vec   = full_vec | part_vec;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (any_vec[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
    win_part = part_vec[win_idx];
  end
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 8,
  parameter int SIZE_W      = 4
) (
  input  logic [XLEN+1:0]             acc_addr,
  input  logic [SIZE_W-1:0]           acc_size,
  input  logic [2:0]                  acc_perm,
  input  logic                        machine_mode,
  input  logic [NUM_ENTRIES*8-1:0]    entry_cfg,
  input  logic [NUM_ENTRIES*XLEN-1:0] entry_addr,
  output logic                        acc_allow
);
  localparam int BND_W = XLEN + 3;
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [CFG_W-1:0]       cfg_arr [NUM_ENTRIES];
  logic [BND_W-1:0]       lo_arr  [NUM_ENTRIES];
  logic [BND_W-1:0]       hi_arr  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] active_vec;
  logic [NUM_ENTRIES-1:0] full_vec;
  logic [NUM_ENTRIES-1:0] part_vec;
  logic [BND_W-1:0]       first_b;
  logic [BND_W-1:0]       last_b;
  logic [BND_W-1:0]       eff_size;
  logic                   win_valid;
  logic [IDX_W-1:0]       win_idx;
  logic                   win_part;
  logic [CFG_W-1:0]       win_cfg;
  logic                   win_lock;
  logic [2:0]             granted;
  logic                   perm_ok;

  always_comb begin
    eff_size = (acc_size == '0) ? BND_W'(1) : BND_W'(acc_size);
    first_b  = {1'b0, acc_addr};
    last_b   = first_b + eff_size - BND_W'(1);
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [XLEN-1:0] prev_addr;
    assign cfg_arr[g] = entry_cfg[g*CFG_W +: CFG_W];
    if (g == 0) begin : g_first
      assign prev_addr = '0;
    end else begin : g_rest
      assign prev_addr = entry_addr[(g-1)*XLEN +: XLEN];
    end

    pmp_region_decode #(.XLEN(XLEN)) u_decode (
      .mode      (cfg_mode(cfg_arr[g])),
      .cur_addr  (entry_addr[g*XLEN +: XLEN]),
      .prev_addr (prev_addr),
      .lo_bound  (lo_arr[g]),
      .hi_bound  (hi_arr[g]),
      .active    (active_vec[g])
    );

    pmp_entry_match #(.BND_W(BND_W)) u_match (
      .active     (active_vec[g]),
      .lo_bound   (lo_arr[g]),
      .hi_bound   (hi_arr[g]),
      .first_byte (first_b),
      .last_byte  (last_b),
      .full_hit   (full_vec[g]),
      .part_hit   (part_vec[g])
    );
  end

  pmp_priority_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_select (
    .full_vec  (full_vec),
    .part_vec  (part_vec),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_part  (win_part)
  );

  always_comb begin
    win_cfg  = cfg_arr[win_idx];
    win_lock = win_cfg[LOCK_BIT];
    granted  = (machine_mode && !win_lock) ? 3'b111 : win_cfg[PERM_W-1:0];
    perm_ok  = ((acc_perm & ~granted) == 3'b000);
    if (active_vec == '0) begin
      acc_allow = 1'b1;
    end else if (win_valid) begin
      acc_allow = !win_part && perm_ok;
    end else begin
      acc_allow = machine_mode;
    end
  end
endmodule

// File: rtl/pmp_access_checker_sva.sv
module pmp_access_checker_sva #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic [NUM_ENTRIES-1:0] active_vec,
  input logic [NUM_ENTRIES-1:0] full_vec,
  input logic [NUM_ENTRIES-1:0] part_vec,
  input logic                   win_valid,
  input logic [IDX_W-1:0]       win_idx,
  input logic                   win_part,
  input logic                   win_lock,
  input logic                   machine_mode,
  input logic                   acc_allow
);
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] below_mask;

  always_comb begin
    hit_vec    = full_vec | part_vec;
    below_mask = (NUM_ENTRIES'(1) << win_idx) - NUM_ENTRIES'(1);

    assert_off_no_hit_R4: assert ((hit_vec & ~active_vec) == '0)
      else $error("off entry produced a hit");

    if (win_valid) begin
      assert_lowest_wins_R5: assert (hit_vec[win_idx] && ((hit_vec & below_mask) == '0))
        else $error("deciding entry is not the lowest hit");
    end

    if (win_valid && win_part) begin
      assert_straddle_denied_R6: assert (!acc_allow)
        else $error("straddling access allowed");
    end

    if (win_valid && !win_part && machine_mode && !win_lock) begin
      assert_mmode_unlocked_R7: assert (acc_allow)
        else $error("unlocked machine access refused");
    end

    if (active_vec == '0) begin
      assert_all_off_allow_R9: assert (acc_allow)
        else $error("access refused with no active entry");
    end

    if ((active_vec != '0) && (hit_vec == '0)) begin
      assert_no_match_mode_R10: assert (acc_allow == machine_mode)
        else $error("no-match fallback wrong");
    end
  end
endmodule

bind pmp_access_checker pmp_access_checker_sva #(.NUM_ENTRIES(NUM_ENTRIES)) u_sva (
  .active_vec   (active_vec),
  .full_vec     (full_vec),
  .part_vec     (part_vec),
  .win_valid    (win_valid),
  .win_idx      (win_idx),
  .win_part     (win_part),
  .win_lock     (win_lock),
  .machine_mode (machine_mode),
  .acc_allow    (acc_allow)
);

// File: tb/pmp_access_checker_tb.sv
`timescale 1ns/1ps
module pmp_access_checker_tb;
  localparam int XLEN = 32;
  localparam int N    = 8;
  localparam int SW   = 4;

  localparam logic [2:0] P_R = 3'b001;
  localparam logic [2:0] P_W = 3'b010;
  localparam logic [2:0] P_X = 3'b100;

  typedef struct packed {
    logic [33:0] addr;
    logic [3:0]  size;
    logic [2:0]  perm;
    logic        mm;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  // Table for the base configuration set up in the stimulus block.
  localparam vec_t VECS [19] = '{
    '{34'h100,  4'd4, P_R,  1'b0, 1'b1, 8'd8},  // R8 NA4 read granted
    '{34'h100,  4'd4, P_W,  1'b0, 1'b0, 8'd8},  // R8 write missing
    '{34'h100,  4'd4, P_W,  1'b1, 1'b1, 8'd7},  // R7 machine, unlocked
    '{34'h102,  4'd4, P_R,  1'b0, 1'b0, 8'd6},  // R6 leaves NA4
    '{34'h104,  4'd4, P_W,  1'b0, 1'b1, 8'd2},  // R2 inside TOR
    '{34'h1FE,  4'd4, P_R,  1'b0, 1'b0, 8'd6},  // R6 leaves TOR top
    '{34'h1000, 4'd4, P_X,  1'b1, 1'b1, 8'd8},  // R8 locked, X granted
    '{34'h1000, 4'd4, P_R,  1'b1, 1'b0, 8'd8},  // R8 locked binds machine
    '{34'h101C, 4'd4, P_X,  1'b0, 1'b1, 8'd3},  // R3 last word of 32B
    '{34'h101E, 4'd4, P_X,  1'b0, 1'b0, 8'd6},  // R6 past 32B end
    '{34'h3000, 4'd4, P_R,  1'b0, 1'b0, 8'd4},  // R4 off entry ignored
    '{34'h3000, 4'd4, P_R,  1'b1, 1'b1, 8'd10}, // R10 machine fallback
    '{34'h2000, 4'd8, P_R,  1'b0, 1'b0, 8'd3},  // R3 8-byte region, no grant
    '{34'h2000, 4'd8, 3'b0, 1'b0, 1'b1, 8'd8},  // R8 empty request
    '{34'h2004, 4'd1, P_R,  1'b1, 1'b1, 8'd7},  // R7 machine in 8B
    '{34'h1FFE, 4'd4, P_R,  1'b1, 1'b0, 8'd6},  // R6 machine straddle
    '{34'h0FC,  4'd8, P_R,  1'b1, 1'b0, 8'd5},  // R5 entry0 holds last byte
    '{34'h100,  4'd0, P_R,  1'b0, 1'b1, 8'd11}, // R11 size zero
    '{34'h103,  4'd1, P_W,  1'b0, 1'b0, 8'd1}   // R1 last byte of NA4
  };

  logic              clk;
  logic [XLEN+1:0]   acc_addr;
  logic [SW-1:0]     acc_size;
  logic [2:0]        acc_perm;
  logic              machine_mode;
  logic [N*8-1:0]    entry_cfg;
  logic [N*XLEN-1:0] entry_addr;
  logic              acc_allow;

  int  n_checks;
  int  n_fail;
  bit  done;

  pmp_access_checker #(.XLEN(XLEN), .NUM_ENTRIES(N), .SIZE_W(SW)) u_dut (
    .acc_addr     (acc_addr),
    .acc_size     (acc_size),
    .acc_perm     (acc_perm),
    .machine_mode (machine_mode),
    .entry_cfg    (entry_cfg),
    .entry_addr   (entry_addr),
    .acc_allow    (acc_allow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic clear_entries();
    entry_cfg  = '0;
    entry_addr = '0;
  endtask

  task automatic set_entry(input int idx, input logic [7:0] cfg, input logic [31:0] wa);
    entry_cfg[idx*8 +: 8]        = cfg;
    entry_addr[idx*XLEN +: XLEN] = wa;
  endtask

  task automatic probe(input logic [33:0] a, input logic [3:0] s, input logic [2:0] p,
                       input logic m, input logic exp, input int req);
    @(posedge clk);
    acc_addr     = a;
    acc_size     = s;
    acc_perm     = p;
    machine_mode = m;
    @(negedge clk);
    n_checks++;
    if (acc_allow !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr=%h size=%0d perm=%b m=%b: got %b expected %b",
               req, a, s, p, m, acc_allow, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    acc_addr = '0;
    acc_size = '0;
    acc_perm = '0;
    machine_mode = 1'b0;
    clear_entries();

    // R9: all entries off, lower mode still allowed
    probe(34'h0, 4'd4, P_W, 1'b0, 1'b1, 9);
    probe(34'h3_FFFF_FFF0, 4'd8, 3'b111, 1'b0, 1'b1, 9);

    // Base configuration for the vector table
    set_entry(0, 8'h11, 32'h0000_0040);  // NA4 0x100, R
    set_entry(1, 8'h0B, 32'h0000_0080);  // TOR up to 0x200, RW
    set_entry(2, 8'h9C, 32'h0000_0403);  // NAPOT 32B at 0x1000, X, locked
    set_entry(3, 8'h07, 32'hFFFF_FFFF);  // off, stale cover-all
    set_entry(4, 8'h18, 32'h0000_0800);  // NAPOT 8B at 0x2000, none
    for (int i = 0; i < 19; i++) begin
      probe(VECS[i].addr, VECS[i].size, VECS[i].perm, VECS[i].mm,
            VECS[i].exp, int'(VECS[i].req));
    end

    // R2: entry 0 top-of-range starts at zero
    clear_entries();
    set_entry(0, 8'h09, 32'h0000_0010);  // TOR [0,0x40), R
    probe(34'h0,  4'd4, P_R, 1'b0, 1'b1, 2);
    probe(34'h3C, 4'd4, P_R, 1'b0, 1'b1, 2);
    probe(34'h40, 4'd4, P_R, 1'b0, 1'b0, 10); // R10 active, no match

    // R2: upper bound below lower bound gives an empty region
    clear_entries();
    set_entry(0, 8'h00, 32'h0000_0010);  // off, still supplies lower bound
    set_entry(1, 8'h0F, 32'h0000_0008);  // TOR [0x40,0x20) empty
    probe(34'h30, 4'd4, P_R, 1'b0, 1'b0, 2);
    probe(34'h30, 4'd4, P_R, 1'b1, 1'b1, 2);

    // R3: power-of-two with all-ones address covers everything
    clear_entries();
    set_entry(0, 8'h19, 32'hFFFF_FFFF);
    probe(34'h3_FFFF_FFFC, 4'd4, P_R, 1'b0, 1'b1, 3);
    probe(34'h0,           4'd4, P_R, 1'b0, 1'b1, 3);
    probe(34'h3_FFFF_FFFC, 4'd4, P_W, 1'b0, 1'b0, 8);
    // R11: last byte past the top of the address space
    probe(34'h3_FFFF_FFFE, 4'd4, P_R, 1'b1, 1'b0, 11);

    finish_run();
  end
endmodule